// File: doc/BRIEF.md
# Video Frame Write Burst Controller

This block moves captured video into a shared frame memory one burst at a time. Active pixel words arrive in a dual-clock FIFO that sits outside the block; the block watches that FIFO's occupancy. Once a full burst of words is waiting, it asks a memory arbiter for the port. When the grant comes, it pulls exactly one burst from the FIFO. When the memory side reports that the burst is finished, it steps a frame write address that walks through word columns, active lines and the two interlaced fields.

The address keeps only active video. Field 0 holds 254 active lines and field 1 holds 253. Each line holds 45 bursts of 8 words, which is 360 words of two pixels each. No blanking lines are ever addressed. A frame-start marker from the capture side puts the walk back at the first burst of field 0.

Top module: `vwb_wr_burst_ctrl`

## Requirements
- R1: While the controller is idle and `fifo_level` is below 8, `wr_req` stays low.
- R2: From idle, a `fifo_level` of 8 or more sampled at a clock edge raises `wr_req` after that edge. `wr_req` holds until a cycle in which `wr_grant` is high, and it is low from the next cycle on.
- R3: `wr_addr` is 25 bits, packed from bit 24 down as follows: 4 zero bits, the 9-bit line number, the field bit, a 2-bit bank that is always zero, the 6-bit burst index, and 3 zero bits. Its value is (line*2+field)*2048 + burst*8.
- R4: After each accepted grant, `fifo_rd_en` is high for exactly 8 consecutive cycles, beginning in the cycle after the grant. It is never high at the same time as `wr_req`.
- R5: The address advances only when `wr_done` is sampled high after the 8 read cycles. A `wr_done` at any other time is ignored, and so is a `wr_grant` that arrives while no request is pending.
- R6: The burst index counts from 0 to 44. A completed burst at index 44 clears the index to 0 and increments the line.
- R7: Field 0 has 254 lines, numbered 0 to 253, and field 1 has 253 lines, numbered 0 to 252. Completing the last burst of a field's last line clears the line and toggles the field, so that field 1 is followed by field 0.
- R8: A `frame_start` sampled high clears the line, field and burst index to zero after that edge. It takes priority over an advance in the same cycle.
- R9: While `rst_n` is low, `wr_req` and `fifo_rd_en` are low and `wr_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_level | input | 6 | Words currently held in the capture FIFO |
| frame_start | input | 1 | Restart the address walk at field 0, line 0, burst 0 |
| wr_grant | input | 1 | Arbiter grants the memory port |
| wr_done | input | 1 | Memory side reports that the burst write is complete |
| wr_req | output | 1 | Request for one burst write |
| wr_addr | output | 25 | Word address of the current burst |
| fifo_rd_en | output | 1 | Pops one word from the capture FIFO |

## Verification
The bench targets the occupancy threshold at 7 and at 8 words. A design with an off-by-one threshold would request with 7 words and drain the FIFO empty, or would wait for a ninth word. The bench delays the grant for several cycles and sends early and stray `wr_done` pulses. A design that dropped its request, read the wrong number of words, or stepped the address before the burst closed would show a mismatch. The bench also runs through a line wrap at burst 44, a field wrap at line 253, and, on a reduced-count instance, the wrap of field 1 back to field 0 and a frame restart. A wrong line count or a miswired field bit would address blanking lines or overwrite the other field.

// File: rtl/vwb_pkg.sv
package vwb_pkg;

   typedef enum logic [1:0] {
      VW_IDLE = 2'd0,
      VW_REQ  = 2'd1,
      VW_XFER = 2'd2,
      VW_FIN  = 2'd3
   } vw_state_t;

endpackage

// File: rtl/vwb_burst_fsm.sv
module vwb_burst_fsm
   import vwb_pkg::*;
#(
   parameter int LVL_W     = 6,
   parameter int BURST_LEN = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] level_i,
   input  logic             grant_i,
   input  logic             done_i,
   output logic             req_o,
   output logic             rd_en_o,
   output logic             adv_o
);

   localparam int BEAT_W = $clog2(BURST_LEN);
   localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

   if (BURST_LEN < 2 || (BURST_LEN & (BURST_LEN - 1)) != 0) begin : g_bad_len
      $error("vwb_burst_fsm: BURST_LEN must be a power of two >= 2");
   end
   if (BURST_LEN > (1 << LVL_W) - 1) begin : g_bad_lvl
      $error("vwb_burst_fsm: LVL_W too narrow to express one burst");
   end

   vw_state_t         state_q, state_d;
   logic [BEAT_W-1:0] beat_q, beat_d;
   logic              enough;

   assign enough = (level_i >= LVL_W'(BURST_LEN));

   always_comb begin
      state_d = state_q;
      beat_d  = beat_q;
      case (state_q)
         VW_IDLE: if (enough) state_d = VW_REQ;
         VW_REQ: begin
            if (grant_i) begin
               state_d = VW_XFER;
               beat_d  = '0;
            end
         end
         VW_XFER: begin
            if (beat_q == LAST_BEAT) state_d = VW_FIN;
            else                     beat_d  = beat_q + 1'b1;
         end
         VW_FIN: if (done_i) state_d = VW_IDLE;
         default: state_d = VW_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= VW_IDLE;
         beat_q  <= '0;
      end else begin
         state_q <= state_d;
         beat_q  <= beat_d;
      end
   end

   assign req_o   = (state_q == VW_REQ);
   assign rd_en_o = (state_q == VW_XFER);
   assign adv_o   = (state_q == VW_FIN) && done_i;

endmodule

// File: rtl/vwb_addr_counter.sv
module vwb_addr_counter #(
   parameter int LINE_W     = 9,
   parameter int BURST_W    = 6,
   parameter int ODD_LINES  = 254,
   parameter int EVEN_LINES = 253,
   parameter int LINE_BURST = 45
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr_i,
   input  logic               adv_i,
   output logic [LINE_W-1:0]  line_o,
   output logic               field_o,
   output logic [BURST_W-1:0] burst_o
);

   localparam logic [BURST_W-1:0] LAST_BURST = BURST_W'(LINE_BURST - 1);
   localparam logic [LINE_W-1:0]  LAST_ODD   = LINE_W'(ODD_LINES - 1);
   localparam logic [LINE_W-1:0]  LAST_EVEN  = LINE_W'(EVEN_LINES - 1);

   if (ODD_LINES < 1 || ODD_LINES > (1 << LINE_W)) begin : g_bad_odd
      $error("vwb_addr_counter: ODD_LINES does not fit LINE_W");
   end
   if (EVEN_LINES < 1 || EVEN_LINES > (1 << LINE_W)) begin : g_bad_even
      $error("vwb_addr_counter: EVEN_LINES does not fit LINE_W");
   end
   if (LINE_BURST < 1 || LINE_BURST > (1 << BURST_W)) begin : g_bad_burst
      $error("vwb_addr_counter: LINE_BURST does not fit BURST_W");
   end

   logic [LINE_W-1:0]  line_q;
   logic               field_q;
   logic [BURST_W-1:0] burst_q;
   logic               end_line, end_field;

   assign end_line  = (burst_q == LAST_BURST);
   assign end_field = end_line && (field_q ? (line_q == LAST_EVEN) : (line_q == LAST_ODD));

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         line_q  <= '0;
         field_q <= 1'b0;
         burst_q <= '0;
      end else if (adv_i) begin
         if (end_field) begin
            burst_q <= '0;
            line_q  <= '0;
            field_q <= ~field_q;
         end else if (end_line) begin
            burst_q <= '0;
            line_q  <= line_q + 1'b1;
         end else begin
            burst_q <= burst_q + 1'b1;
         end
      end
   end

   assign line_o  = line_q;
   assign field_o = field_q;
   assign burst_o = burst_q;

endmodule

// File: rtl/vwb_addr_pack.sv
module vwb_addr_pack #(
   parameter int ROW_PAD = 4,
   parameter int LINE_W  = 9,
   parameter int BANK_W  = 2,
   parameter int BURST_W = 6,
   parameter int OFS_W   = 3,
   localparam int ADDR_W = ROW_PAD + LINE_W + 1 + BANK_W + BURST_W + OFS_W
) (
   input  logic [LINE_W-1:0]  line_i,
   input  logic               field_i,
   input  logic [BURST_W-1:0] burst_i,
   output logic [ADDR_W-1:0]  addr_o
);

   if (BANK_W < 1 || OFS_W < 1) begin : g_bad_fields
      $error("vwb_addr_pack: BANK_W and OFS_W must be at least 1");
   end

   if (ROW_PAD > 0) begin : g_padded
      assign addr_o = {{ROW_PAD{1'b0}}, line_i, field_i,
                       {BANK_W{1'b0}}, burst_i, {OFS_W{1'b0}}};
   end else begin : g_unpadded
      assign addr_o = {line_i, field_i, {BANK_W{1'b0}}, burst_i, {OFS_W{1'b0}}};
   end

endmodule

// File: rtl/vwb_wr_burst_ctrl.sv
module vwb_wr_burst_ctrl #(
   parameter int LVL_W      = 6,
   parameter int BURST_LEN  = 8,
   parameter int ROW_PAD    = 4,
   parameter int LINE_W     = 9,
   parameter int BANK_W     = 2,
   parameter int BURST_W    = 6,
   parameter int ODD_LINES  = 254,
   parameter int EVEN_LINES = 253,
   parameter int LINE_BURST = 45,
   localparam int OFS_W     = $clog2(BURST_LEN),
   localparam int ADDR_W    = ROW_PAD + LINE_W + 1 + BANK_W + BURST_W + OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LVL_W-1:0]  fifo_level,
   input  logic              frame_start,
   input  logic              wr_grant,
   input  logic              wr_done,
   output logic              wr_req,
   output logic [ADDR_W-1:0] wr_addr,
   output logic              fifo_rd_en
);

   logic               adv;
   logic [LINE_W-1:0]  line;
   logic               field;
   logic [BURST_W-1:0] burst;

   vwb_burst_fsm #(
      .LVL_W    (LVL_W),
      .BURST_LEN(BURST_LEN)
   ) u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .level_i(fifo_level),
      .grant_i(wr_grant),
      .done_i (wr_done),
      .req_o  (wr_req),
      .rd_en_o(fifo_rd_en),
      .adv_o  (adv)
   );

   vwb_addr_counter #(
      .LINE_W    (LINE_W),
      .BURST_W   (BURST_W),
      .ODD_LINES (ODD_LINES),
      .EVEN_LINES(EVEN_LINES),
      .LINE_BURST(LINE_BURST)
   ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (frame_start),
      .adv_i  (adv),
      .line_o (line),
      .field_o(field),
      .burst_o(burst)
   );

   vwb_addr_pack #(
      .ROW_PAD(ROW_PAD),
      .LINE_W (LINE_W),
      .BANK_W (BANK_W),
      .BURST_W(BURST_W),
      .OFS_W  (OFS_W)
   ) u_pack (
      .line_i (line),
      .field_i(field),
      .burst_i(burst),
      .addr_o (wr_addr)
   );

endmodule

// File: rtl/vwb_wr_burst_chk.sv
module vwb_wr_burst_chk #(
   parameter int LVL_W      = 6,
   parameter int BURST_LEN  = 8,
   parameter int LINE_W     = 9,
   parameter int BANK_W     = 2,
   parameter int BURST_W    = 6,
   parameter int ODD_LINES  = 254,
   parameter int EVEN_LINES = 253,
   parameter int LINE_BURST = 45,
   parameter int OFS_W      = 3,
   parameter int ADDR_W     = 25
) (
   input logic              clk,
   input logic              rst_n,
   input logic [LVL_W-1:0]  fifo_level,
   input logic              frame_start,
   input logic              wr_grant,
   input logic              wr_done,
   input logic              wr_req,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              fifo_rd_en
);

   localparam int FLD_POS  = OFS_W + BURST_W + BANK_W;
   localparam int LINE_POS = FLD_POS + 1;

   int run_q;

   always_ff @(posedge clk) begin
      if (!rst_n)          run_q <= 0;
      else if (fifo_rd_en) run_q <= run_q + 1;
      else                 run_q <= 0;
   end

   // R1
   a_r1_no_req_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_req && !fifo_rd_en && fifo_level < LVL_W'(BURST_LEN)) |=> !wr_req);

   // R2
   a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_grant) |=> wr_req);

   a_r2_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && wr_grant) |=> (!wr_req && fifo_rd_en));

   // R4
   a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_req && fifo_rd_en));

   a_r4_max_len: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd_en |-> (run_q < BURST_LEN));

   a_r4_full_len: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fifo_rd_en) |-> (run_q == BURST_LEN));

   // R5
   a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_rd_en && !frame_start) |=> $stable(wr_addr));

   // R6
   a_r6_burst_range: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_addr[OFS_W +: BURST_W] < BURST_W'(LINE_BURST)));

   // R7
   a_r7_line_range: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_addr[FLD_POS] ? (wr_addr[LINE_POS +: LINE_W] < LINE_W'(EVEN_LINES))
                        : (wr_addr[LINE_POS +: LINE_W] < LINE_W'(ODD_LINES))));

   // R8
   a_r8_frame_clear: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (wr_addr == '0));

endmodule

bind vwb_wr_burst_ctrl vwb_wr_burst_chk #(
   .LVL_W     (LVL_W),
   .BURST_LEN (BURST_LEN),
   .LINE_W    (LINE_W),
   .BANK_W    (BANK_W),
   .BURST_W   (BURST_W),
   .ODD_LINES (ODD_LINES),
   .EVEN_LINES(EVEN_LINES),
   .LINE_BURST(LINE_BURST),
   .OFS_W     (OFS_W),
   .ADDR_W    (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fifo_level (fifo_level),
   .frame_start(frame_start),
   .wr_grant   (wr_grant),
   .wr_done    (wr_done),
   .wr_req     (wr_req),
   .wr_addr    (wr_addr),
   .fifo_rd_en (fifo_rd_en)
);

// File: tb/vwb_wr_burst_ctrl_test.sv
module vwb_ref_model #(
   parameter int ODD_L = 254,
   parameter int EVEN_L = 253,
   parameter int BPL = 45
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [5:0]  level,
   input  logic        grant,
   input  logic        done,
   input  logic        fstart,
   output logic        e_req,
   output logic        e_rd,
   output logic [24:0] e_addr
);
   int phase = 0;   // 0 waiting, 1 asking, 2 reading, 3 closing
   int beats = 0;
   int b = 0, ln = 0, fl = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         phase = 0; beats = 0; b = 0; ln = 0; fl = 0;
      end else begin
         if (phase == 0) begin
            if (level >= 8) phase = 1;
         end else if (phase == 1) begin
            if (grant) begin phase = 2; beats = 0; end
         end else if (phase == 2) begin
            beats++;
            if (beats == 8) phase = 3;
         end else begin
            if (done) begin
               phase = 0;
               b++;
               if (b == BPL) begin
                  b = 0; ln++;
                  if (ln == (fl ? EVEN_L : ODD_L)) begin ln = 0; fl = 1 - fl; end
               end
            end
         end
         if (fstart) begin b = 0; ln = 0; fl = 0; end
      end
   end

   assign e_req  = (phase == 1);
   assign e_rd   = (phase == 2);
   assign e_addr = 25'((ln * 2 + fl) * 2048 + b * 8);
endmodule

module vwb_wr_burst_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  lvl = 6'd0;
   logic        fstart = 1'b0, grant = 1'b0, done = 1'b0;
   logic        req, rd, req_s, rd_s, e_req, e_rd, e_req_s, e_rd_s;
   logic [24:0] addr, addr_s, e_addr, e_addr_s;
   int          errors = 0, checks = 0;
   bit          live = 1'b0;

   always #4 clk = ~clk;

   vwb_wr_burst_ctrl uut (
      .clk(clk), .rst_n(rst_n), .fifo_level(lvl), .frame_start(fstart),
      .wr_grant(grant), .wr_done(done), .wr_req(req), .wr_addr(addr), .fifo_rd_en(rd));

   vwb_wr_burst_ctrl #(.ODD_LINES(3), .EVEN_LINES(2), .LINE_BURST(4)) uut_s (
      .clk(clk), .rst_n(rst_n), .fifo_level(lvl), .frame_start(fstart),
      .wr_grant(grant), .wr_done(done), .wr_req(req_s), .wr_addr(addr_s), .fifo_rd_en(rd_s));

   vwb_ref_model ref_m (
      .clk(clk), .rst_n(rst_n), .level(lvl), .grant(grant), .done(done), .fstart(fstart),
      .e_req(e_req), .e_rd(e_rd), .e_addr(e_addr));

   vwb_ref_model #(.ODD_L(3), .EVEN_L(2), .BPL(4)) ref_s (
      .clk(clk), .rst_n(rst_n), .level(lvl), .grant(grant), .done(done), .fstart(fstart),
      .e_req(e_req_s), .e_rd(e_rd_s), .e_addr(e_addr_s));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // every-cycle comparison against the behavioural model
   always @(negedge clk) begin
      if (live) begin
         chk(req == e_req,     "R2 wr_req vs model",   int'(req),   int'(e_req));
         chk(rd == e_rd,       "R4 rd_en vs model",    int'(rd),    int'(e_rd));
         chk(addr == e_addr,   "R3 addr vs model",     int'(addr),  int'(e_addr));
         chk(req_s == e_req_s, "R2 small wr_req",      int'(req_s), int'(e_req_s));
         chk(rd_s == e_rd_s,   "R4 small rd_en",       int'(rd_s),  int'(e_rd_s));
         chk(addr_s == e_addr_s, "R7 small addr",      int'(addr_s), int'(e_addr_s));
      end
   end

   // one granted burst, arbiter answering immediately
   task automatic one_burst();
      while (!req) @(negedge clk);
      grant = 1'b1;
      @(negedge clk);
      grant = 1'b0;
      while (rd) @(negedge clk);
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
   endtask

   task automatic run_all();
      int n;
      repeat (4) @(negedge clk);
      chk(req == 1'b0, "R9 reset wr_req", int'(req), 0);
      chk(rd == 1'b0,  "R9 reset rd_en",  int'(rd), 0);
      chk(addr == 25'd0, "R9 reset addr", int'(addr), 0);
      rst_n = 1'b1;
      live = 1'b1;
      // R1: seven words never request
      lvl = 6'd7;
      repeat (10) begin
         @(negedge clk);
         chk(req == 1'b0, "R1 no request below 8", int'(req), 0);
      end
      // R5: stray grant with no request
      grant = 1'b1;
      @(negedge clk);
      grant = 1'b0;
      @(negedge clk);
      chk(rd == 1'b0, "R5 stray grant ignored", int'(rd), 0);
      // R2: request at 8 words, held without grant
      lvl = 6'd8;
      @(negedge clk);
      chk(req == 1'b1, "R2 request at 8 words", int'(req), 1);
      lvl = 6'd20;
      repeat (5) begin
         @(negedge clk);
         chk(req == 1'b1, "R2 request held", int'(req), 1);
      end
      grant = 1'b1;
      @(negedge clk);
      grant = 1'b0;
      chk(req == 1'b0, "R2 request dropped after grant", int'(req), 0);
      // R4: count read cycles, pulse an early done (R5)
      n = 0;
      while (rd) begin
         n++;
         done = (n == 3);
         @(negedge clk);
      end
      done = 1'b0;
      chk(n == 8, "R4 eight read cycles", n, 8);
      repeat (3) @(negedge clk);
      chk(addr == 25'd0, "R5 no advance before done", int'(addr), 0);
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
      chk(addr == 25'd8, "R3 second burst address", int'(addr), 8);
      // R6: line wrap after burst 44; total 50 bursts -> line 1 burst 5
      repeat (49) one_burst();
      chk(addr == 25'd4136, "R6 line 1 burst 5", int'(addr), 4136);
      // R8: frame restart
      fstart = 1'b1;
      @(negedge clk);
      fstart = 1'b0;
      chk(addr == 25'd0, "R8 frame start clears", int'(addr), 0);
      chk(addr_s == 25'd0, "R8 small frame start clears", int'(addr_s), 0);
      // R7: full field 0 (254 lines x 45 bursts)
      repeat (11430) one_burst();
      chk(addr == 25'd2048, "R7 field 1 line 0 after 254 lines", int'(addr), 2048);
      chk(addr_s == 25'd8208, "R7 small instance after wraps", int'(addr_s), 8208);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (195000) @(posedge clk);
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=timeout expected=finish");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule